// File: doc/BRIEF.md
# Serial Short-Frame Check Word Generator and Checker

This block computes a 16-bit cyclic check word over a serial bit stream, one bit per clock, for frames of at most 255 bits including the check word. The divisor is the 16-bit generator of the shortened (255,239) binary BCH code rather than a common CRC divisor. Within the length limit, any combination of up to four flipped bits in a frame is detected. An optional whole-frame parity bit extends the frame to 256 bits while keeping the 239-bit data capacity.

A frame is delimited by a start marker on its first valid bit and an end marker on its last valid bit. In generate mode the frame carries data only, and the block returns the check word and the parity bit to append. In check mode the frame carries data, then the 16 received check bits (most significant first), then the parity bit when parity is enabled. The block raises an error flag if the remainder is non-zero, if the parity is wrong, or if the frame is too long. The mode and the parity enable are taken from the first bit of each frame.

Top module: `bch_frame_crc`

## Requirements
- R1: In generate mode (`mode_chk`=0), one cycle after the end bit `crc_word` equals the remainder of the data bits (first bit = highest power) times x^16, divided by x^16+x^14+x^13+x^11+x^10+x^9+x^8+x^6+x^5+x+1. Example: the one-bit frame "1" gives 16'h6F63. In this mode `frame_err` equals `len_ovf`.
- R2: In check mode (`mode_chk`=1), a frame of data followed by its correct 16 check bits, most significant first, gives `frame_err`=0 and `crc_word`=0.
- R3: In check mode, any 1, 2, 3 or 4 flipped bits in a frame of up to 255 bits give `frame_err`=1.
- R4: In generate mode, `parity_bit` is the XOR of all data bits and all 16 check bits. In check mode with `parity_en`=1, the last bit is a parity bit that does not enter the divider, and an odd count of ones over the whole frame sets `frame_err`.
- R5: In generate mode, more than 239 data bits set `len_ovf` and `frame_err` at frame end. Exactly 239 bits do not.
- R6: In check mode, the limit is 255 bits, or 256 bits with `parity_en`=1. One bit more sets `len_ovf` and `frame_err`.
- R7: `frame_done` pulses for exactly one cycle, one cycle after the end bit is accepted. `frame_err` and `len_ovf` are high only during that pulse, and are low after reset.
- R8: Bits with `bit_valid`=0, and valid bits that arrive outside a frame before a start marker, have no effect on the result. A start marker during a frame restarts the computation.
- R9: `crc_word` and `parity_bit` are 0 after reset, and hold their value from one frame end until the next frame end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_chk | input | 1 | 0 = generate, 1 = check; sampled with the start bit |
| parity_en | input | 1 | Enables the whole-frame parity bit; sampled with the start bit |
| bit_valid | input | 1 | Qualifies bit_in, sof and eof |
| bit_in | input | 1 | Serial data bit |
| sof | input | 1 | Marks the first bit of a frame |
| eof | input | 1 | Marks the last bit of a frame |
| crc_word | output | 16 | Check word (generate) or remainder (check) of the last frame |
| parity_bit | output | 1 | Parity bit to append (generate) or overall parity seen (check) |
| frame_done | output | 1 | One-cycle frame-complete pulse |
| frame_err | output | 1 | Frame error, valid with frame_done |
| len_ovf | output | 1 | Length limit exceeded, valid with frame_done |

## Verification
A corrupted divider register stays hidden until the end bit. It then appears at once, one cycle later, as a wrong `crc_word` in generate mode or as a false `frame_err` on a valid codeword in check mode. The one-bit frame and frames built by independent long division expose this. A stuck or misaligned length counter shows only at the limit, so frames of exactly the limit and one bit past it are run for each mode and each parity setting. Any state left over from a previous frame or from idle bits would change the next result, and the gap and restart scenarios are built to reveal that.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] GEN_TAPS = 16'h6F63;
    localparam int FRAME_MAX_BITS = 255;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } crc_mode_e;

    typedef struct packed {
        logic [CRC_W-1:0] rem;
        logic             par;
    } acc_t;

    function automatic logic [CRC_W-1:0] lfsr_step(
        input logic [CRC_W-1:0] r,
        input logic             b,
        input logic [CRC_W-1:0] taps
    );
        logic fb;
        fb = b ^ r[CRC_W-1];
        return {r[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & taps);
    endfunction

endpackage

// File: rtl/bch_lfsr.sv
module bch_lfsr
    import bchk_pkg::*;
#(
    parameter logic [CRC_W-1:0] TAPS = GEN_TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic start,
    input  logic shift,
    input  logic bit_in,
    output acc_t acc_nxt
);

    acc_t acc_q;
    acc_t base;

    always_comb begin
        base = start ? '0 : acc_q;
        acc_nxt.rem = shift ? lfsr_step(base.rem, bit_in, TAPS) : base.rem;
        acc_nxt.par = take ? (base.par ^ bit_in) : base.par;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/bch_len_guard.sv
module bch_len_guard #(
    parameter int CNT_W     = 9,
    parameter int FRAME_MAX = 255,
    parameter int CW        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             start,
    input  logic             chk,
    input  logic             pen,
    output logic             ovf_nxt,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LIM_GEN = CNT_W'(FRAME_MAX - CW);
    localparam logic [CNT_W-1:0] LIM_CHK = CNT_W'(FRAME_MAX);

    logic             ovf_q;
    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_nxt;
    logic             over;

    always_comb begin
        base_cnt = start ? '0 : cnt;
        limit    = chk ? (LIM_CHK + CNT_W'(pen)) : LIM_GEN;
        over     = take && (base_cnt >= limit);
        ovf_nxt  = (start ? 1'b0 : ovf_q) || over;
        cnt_nxt  = (take && !over) ? (base_cnt + 1'b1) : base_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ovf_q <= 1'b0;
        end else if (take) begin
            cnt   <= cnt_nxt;
            ovf_q <= ovf_nxt;
        end
    end

endmodule

// File: rtl/bch_frame_crc.sv
module bch_frame_crc
    import bchk_pkg::*;
#(
    parameter logic [CRC_W-1:0] TAPS      = GEN_TAPS,
    parameter int               FRAME_MAX = FRAME_MAX_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_chk,
    input  logic             parity_en,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             sof,
    input  logic             eof,
    output logic [CRC_W-1:0] crc_word,
    output logic             parity_bit,
    output logic             frame_done,
    output logic             frame_err,
    output logic             len_ovf
);

    localparam int CNT_W = $clog2(FRAME_MAX + 2);

    crc_mode_e        mode_q;
    crc_mode_e        mode_cur;
    logic             pen_q;
    logic             pen_cur;
    logic             in_frame;
    logic             take;
    logic             par_only;
    logic             shift;
    acc_t             acc_nxt;
    logic             ovf_nxt;
    logic [CNT_W-1:0] len_cnt;

    always_comb begin
        take     = bit_valid && (sof || in_frame);
        mode_cur = sof ? crc_mode_e'(mode_chk) : mode_q;
        pen_cur  = sof ? parity_en : pen_q;
        par_only = (mode_cur == MODE_CHK) && pen_cur && eof;
        shift    = take && !par_only;
    end

    bch_lfsr #(
        .TAPS (TAPS)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .start   (sof),
        .shift   (shift),
        .bit_in  (bit_in),
        .acc_nxt (acc_nxt)
    );

    bch_len_guard #(
        .CNT_W     (CNT_W),
        .FRAME_MAX (FRAME_MAX),
        .CW        (CRC_W)
    ) u_guard (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .start   (sof),
        .chk     (mode_cur == MODE_CHK),
        .pen     (pen_cur),
        .ovf_nxt (ovf_nxt),
        .cnt     (len_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame   <= 1'b0;
            mode_q     <= MODE_GEN;
            pen_q      <= 1'b0;
            crc_word   <= '0;
            parity_bit <= 1'b0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
            len_ovf    <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
            len_ovf    <= 1'b0;
            if (take) begin
                mode_q   <= mode_cur;
                pen_q    <= pen_cur;
                in_frame <= !eof;
                if (eof) begin
                    frame_done <= 1'b1;
                    crc_word   <= acc_nxt.rem;
                    len_ovf    <= ovf_nxt;
                    if (mode_cur == MODE_GEN) begin
                        parity_bit <= acc_nxt.par ^ (^acc_nxt.rem);
                        frame_err  <= ovf_nxt;
                    end else begin
                        parity_bit <= acc_nxt.par;
                        frame_err  <= ovf_nxt || (|acc_nxt.rem) ||
                                      (pen_cur && acc_nxt.par);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bch_frame_crc_chk.sv
module bch_frame_crc_chk
    import bchk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_valid,
    input logic             eof,
    input logic [CRC_W-1:0] crc_word,
    input logic             parity_bit,
    input logic             frame_done,
    input logic             frame_err,
    input logic             len_ovf,
    input crc_mode_e        mode_q
);

    AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> frame_done); // R7

    AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(bit_valid && eof)); // R7

    AST_OVF_FLAGS_ERR: assert property (@(posedge clk) disable iff (rst)
        len_ovf |-> (frame_err && frame_done)); // R5

    AST_GEN_ERR_IS_OVF: assert property (@(posedge clk) disable iff (rst)
        (frame_done && mode_q == MODE_GEN) |-> (frame_err == len_ovf)); // R1

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_done |-> ($stable(crc_word) && $stable(parity_bit))); // R9

endmodule

bind bch_frame_crc bch_frame_crc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .eof        (eof),
    .crc_word   (crc_word),
    .parity_bit (parity_bit),
    .frame_done (frame_done),
    .frame_err  (frame_err),
    .len_ovf    (len_ovf),
    .mode_q     (mode_q)
);

// File: tb/bch_frame_crc_test.sv
module bch_frame_crc_test;

    localparam logic [16:0] GEN17 = 17'h16F63;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_chk = 1'b0;
    logic        parity_en = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        sof = 1'b0;
    logic        eof = 1'b0;
    logic [15:0] crc_word;
    logic        parity_bit;
    logic        frame_done;
    logic        frame_err;
    logic        len_ovf;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        frm [0:299];
    int          frm_len = 0;

    logic [15:0] s_crc;
    logic        s_par, s_done, s_err, s_ovf, a_done, a_err;

    bch_frame_crc uut (
        .clk        (clk),
        .rst        (rst),
        .mode_chk   (mode_chk),
        .parity_en  (parity_en),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .sof        (sof),
        .eof        (eof),
        .crc_word   (crc_word),
        .parity_bit (parity_bit),
        .frame_done (frame_done),
        .frame_err  (frame_err),
        .len_ovf    (len_ovf)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build_data(input int n, input int unsigned seed);
        int unsigned s;
        s = seed;
        for (int i = 0; i < n; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            frm[i] = s[16];
        end
        frm_len = n;
    endtask

    function automatic logic [15:0] ref_rem(input int n);
        logic        w [0:320];
        logic [15:0] r;
        for (int i = 0; i < n; i++) w[i] = frm[i];
        for (int i = n; i < n + 16; i++) w[i] = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (w[i]) begin
                for (int k = 0; k <= 16; k++) w[i+k] = w[i+k] ^ GEN17[16-k];
            end
        end
        for (int k = 0; k < 16; k++) r[15-k] = w[n+k];
        return r;
    endfunction

    function automatic logic xor_bits(input int n);
        logic p;
        p = 1'b0;
        for (int i = 0; i < n; i++) p = p ^ frm[i];
        return p;
    endfunction

    task automatic append_crc();
        logic [15:0] r;
        r = ref_rem(frm_len);
        for (int k = 0; k < 16; k++) frm[frm_len+k] = r[15-k];
        frm_len = frm_len + 16;
    endtask

    task automatic append_par();
        frm[frm_len] = xor_bits(frm_len);
        frm_len = frm_len + 1;
    endtask

    task automatic run_frame(input logic m, input logic pe, input bit gaps);
        for (int i = 0; i < frm_len; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                bit_valid = 1'b0; bit_in = ~frm[i]; sof = 1'b1; eof = 1'b1;
            end
            @(negedge clk);
            bit_valid = 1'b1; bit_in = frm[i];
            sof = (i == 0); eof = (i == frm_len - 1);
            mode_chk = m; parity_en = pe;
        end
        @(negedge clk);
        bit_valid = 1'b0; sof = 1'b0; eof = 1'b0; bit_in = 1'b0;
        s_crc = crc_word; s_par = parity_bit; s_done = frame_done;
        s_err = frame_err; s_ovf = len_ovf;
        @(negedge clk);
        a_done = frame_done; a_err = frame_err;
    endtask

    task automatic t_reset();
        check(crc_word == 16'h0, "R9", "crc_word after reset", crc_word, 0);
        check(!frame_done && !frame_err && !len_ovf, "R7", "flags after reset",
              {frame_done, frame_err, len_ovf}, 0);
    endtask

    task automatic t_gen_basic();
        logic [15:0] r;
        frm[0] = 1'b1; frm_len = 1;
        run_frame(1'b0, 1'b0, 1'b0);
        check(s_crc == 16'h6F63, "R1", "crc of single one", s_crc, 16'h6F63);
        check(s_done && !s_err && !s_ovf, "R7", "done pulse, no error",
              {s_done, s_err, s_ovf}, 3'b100);
        check(!a_done && !a_err, "R7", "pulse one cycle", {a_done, a_err}, 0);
        build_data(37, 32'd7);
        r = ref_rem(37);
        run_frame(1'b0, 1'b0, 1'b0);
        check(s_crc == r, "R1", "crc of 37-bit frame", s_crc, r);
        check(s_par == (xor_bits(37) ^ (^r)), "R4", "generated parity",
              s_par, xor_bits(37) ^ (^r));
    endtask

    task automatic t_check_good();
        build_data(40, 32'd99);
        append_crc();
        run_frame(1'b1, 1'b0, 1'b0);
        check(s_done && !s_err, "R2", "valid codeword accepted", s_err, 0);
        check(s_crc == 16'h0, "R2", "zero remainder", s_crc, 0);
    endtask

    task automatic t_check_errors();
        int pos [0:3];
        pos[0] = 0; pos[1] = 17; pos[2] = 41; pos[3] = 55;
        for (int n = 1; n <= 4; n++) begin
            build_data(40, 32'd99);
            append_crc();
            for (int j = 0; j < n; j++) frm[pos[j]] = ~frm[pos[j]];
            run_frame(1'b1, 1'b0, 1'b0);
            check(s_done && s_err, "R3", $sformatf("%0d flipped bits", n), s_err, 1);
        end
        build_data(200, 32'd5);
        append_crc();
        frm[3] = ~frm[3]; frm[90] = ~frm[90]; frm[150] = ~frm[150]; frm[214] = ~frm[214];
        run_frame(1'b1, 1'b0, 1'b0);
        check(s_err, "R3", "4 flips in 216-bit frame", s_err, 1);
    endtask

    task automatic t_parity();
        build_data(30, 32'd11);
        append_crc();
        append_par();
        run_frame(1'b1, 1'b1, 1'b0);
        check(s_done && !s_err, "R4", "good parity frame", s_err, 0);
        frm[frm_len-1] = ~frm[frm_len-1];
        run_frame(1'b1, 1'b1, 1'b0);
        check(s_err && !s_ovf, "R4", "wrong parity bit", {s_err, s_ovf}, 2'b10);
        check(s_crc == 16'h0, "R4", "parity bit kept out of divider", s_crc, 0);
    endtask

    task automatic t_gaps();
        logic [15:0] r;
        build_data(25, 32'd321);
        r = ref_rem(25);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            bit_valid = 1'b1; bit_in = 1'b1; sof = 1'b0; eof = (i == 2);
        end
        run_frame(1'b0, 1'b0, 1'b1);
        check(s_crc == r, "R8", "idle and stray bits ignored", s_crc, r);
    endtask

    task automatic t_hold_restart();
        logic [15:0] r;
        logic [15:0] held;
        logic        ok;
        build_data(20, 32'd44);
        run_frame(1'b0, 1'b0, 1'b0);
        held = s_crc;
        ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            bit_valid = 1'b1; bit_in = i[0]; sof = (i == 0); eof = 1'b0;
            mode_chk = 1'b0; parity_en = 1'b0;
            if (crc_word != held || frame_done) ok = 1'b0;
        end
        check(ok, "R9", "result held during next frame", crc_word, held);
        build_data(33, 32'd8);
        r = ref_rem(33);
        run_frame(1'b0, 1'b0, 1'b0);
        check(s_crc == r, "R8", "start marker restarts frame", s_crc, r);
    endtask

    task automatic t_len_gen();
        build_data(239, 32'd3);
        run_frame(1'b0, 1'b0, 1'b0);
        check(!s_ovf && !s_err, "R5", "239 data bits", {s_ovf, s_err}, 0);
        build_data(240, 32'd3);
        run_frame(1'b0, 1'b0, 1'b0);
        check(s_ovf && s_err, "R5", "240 data bits", {s_ovf, s_err}, 2'b11);
    endtask

    task automatic t_len_chk();
        build_data(239, 32'd21);
        append_crc();
        run_frame(1'b1, 1'b0, 1'b0);
        check(!s_ovf && !s_err, "R6", "255-bit check frame", {s_ovf, s_err}, 0);
        build_data(240, 32'd21);
        append_crc();
        run_frame(1'b1, 1'b0, 1'b0);
        check(s_ovf && s_err, "R6", "256 bits without parity", {s_ovf, s_err}, 2'b11);
        build_data(239, 32'd21);
        append_crc();
        append_par();
        run_frame(1'b1, 1'b1, 1'b0);
        check(!s_ovf && !s_err, "R6", "256 bits with parity", {s_ovf, s_err}, 0);
        build_data(240, 32'd21);
        append_crc();
        append_par();
        run_frame(1'b1, 1'b1, 1'b0);
        check(s_ovf && s_err, "R6", "257 bits with parity", {s_ovf, s_err}, 2'b11);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_gen_basic();
        t_check_good();
        t_check_errors();
        t_parity();
        t_gaps();
        t_hold_restart();
        t_len_gen();
        t_len_chk();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule